// File: doc/BRIEF.md
# Two-Stage Decade Counter with Gated Clear and Preset

A four-bit counter made of two independent stages. A two-state stage drives bit 0 of the output. A five-state stage drives bits 3 to 1. Each stage advances on a falling edge of its own count input. Both count inputs are level signals, sampled by the system clock. A falling edge is a sample of one followed by a sample of zero. Because the two stages are separate, a user can wire them into a binary-coded-decimal counter by feeding output bit 0 back into the five-state stage's count input. Each next stage in a chain then takes bit 3, which falls once per wrap from nine to zero.

Two gated controls act on the whole counter whatever the count inputs do. The clear needs both of its inputs high, and it forces the output to zero. The preset also needs both of its inputs high. It forces the output to nine (binary 1001) and wins over the clear. Tying the clear inputs to decoded output bits gives counters with a smaller modulus. For example, clearing when bits 2 and 1 are both high gives a count of 0 to 5.

The controls and the count inputs take effect on the first system clock edge at which they are sampled. The output comes straight from registers, so output-derived feedback forms no combinational loop.

Top module: `dual_decade_counter`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, `q_out` becomes 0000 after that edge.
- R2: A falling edge of `tick_a` toggles `q_out[0]` at the next `clk` edge. It does not change `q_out[3:1]`.
- R3: A falling edge of `tick_b` moves `q_out[3:1]` through 000, 001, 010, 011, 100 and back to 000, one step at the next `clk` edge. It does not change `q_out[0]`.
- R4: A rising edge or a steady level on a count input does not change `q_out`. A single high clear input or a single high preset input does not change `q_out` either.
- R5: With `clr_a` and `clr_b` both high and the preset not active, `q_out` is 0000 after the next `clk` edge and stays 0000 while the clear is held, even if count edges arrive.
- R6: With `nine_a` and `nine_b` both high, `q_out` is 1001 after the next `clk` edge. This holds whatever the clear inputs and count edges do.
- R7: With `tick_b` driven from `q_out[0]`, pulses on `tick_a` give the counts 0 to 9 in BCD and then 0 again. `q_out[3]` falls on the step from 9 to 0.
- R8: With `tick_b` driven from `q_out[0]` and both clear inputs driven from `q_out[2] & q_out[1]`, the settled counts run 0 to 5 and then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_a | input | 1 | Count input of the two-state stage; acts on a falling edge |
| tick_b | input | 1 | Count input of the five-state stage; acts on a falling edge |
| clr_a | input | 1 | Clear input, ANDed with `clr_b` |
| clr_b | input | 1 | Clear input, ANDed with `clr_a` |
| nine_a | input | 1 | Preset-to-nine input, ANDed with `nine_b` |
| nine_b | input | 1 | Preset-to-nine input, ANDed with `nine_a` |
| q_out | output | 4 | Count; bit 0 from the two-state stage, bits 3..1 from the five-state stage |

## Verification
The assertions take for granted that the count, clear and preset inputs change only between rising `clk` edges. They also assume each count input level lasts at least one clock, so that a falling edge is seen by sampling. The bench meets this by changing every input on the falling clock edge. It keeps each count pulse high for one full cycle and low for at least three cycles. It drives the wired feedback (bit 0 into the count input, decoded bits into the clear) from registered outputs, so the feedback also changes only after a rising edge.

// File: rtl/ddc_pkg.sv
// Package: shared types for the two-stage decade counter.
// Assumes: nothing beyond standard SystemVerilog.
package ddc_pkg;
    // What one stage does at the next clock edge, in priority order.
    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_STEP   = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_PRESET = 2'd3
    } stage_act_e;
endpackage

// File: rtl/ddc_fall_detect.sv
// Module: ddc_fall_detect
// Gives a one-cycle pulse when the sampled level input goes from 1 to 0.
// Assumes: lvl_in is stable around rising clk edges (driven synchronously).
module ddc_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic fall
);
    logic prev;

    // Remember the level seen at the last edge; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl_in;
    end

    // Falling edge: was high, now low.
    always_comb fall = prev & ~lvl_in;

    // R4: the pulse never lasts two cycles in a row.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/ddc_stage.sv
// Module: ddc_stage
// Modulo-MOD counter stage. Holds, steps, clears to 0 or loads PRESET
// as ordered by the decoded action.
// Assumes: MOD >= 2 and PRESET < MOD.
module ddc_stage
    import ddc_pkg::*;
#(
    parameter int MOD    = 5,
    parameter int PRESET = 4,
    localparam int W     = (MOD > 1) ? $clog2(MOD) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  stage_act_e   act,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);
    localparam logic [W-1:0] LOAD = W'(PRESET);
    localparam logic [W-1:0] ONE  = W'(1);

    // Count state update under the decoded action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case (act)
                ACT_PRESET: cnt <= LOAD;
                ACT_CLEAR:  cnt <= '0;
                ACT_STEP:   cnt <= (cnt == LAST) ? '0 : cnt + ONE;
                default:    cnt <= cnt;
            endcase
        end
    end

    // R1: reset leaves the stage at zero.
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> cnt == '0);
    // R3: the stage never leaves its modulus range.
    a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R2: a step moves to the successor, wrapping after the last state.
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_STEP |=> cnt == (($past(cnt) == LAST) ? '0 : $past(cnt) + ONE));
    // R4: without an action the count is kept.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_HOLD |=> $stable(cnt));
endmodule

// File: rtl/dual_decade_counter.sv
// Module: dual_decade_counter (top)
// Two-stage counter: a modulo-A_MOD stage on the low bits and a
// modulo-B_MOD stage on the high bits, each advanced by falling edges
// of its own count input. A gated clear and a gated preset (preset wins)
// act on both stages.
// Assumes: inputs change away from rising clk edges; with the default
// parameters the preset value A_PRESET/B_PRESET gives 1001.
module dual_decade_counter
    import ddc_pkg::*;
#(
    parameter int A_MOD    = 2,
    parameter int B_MOD    = 5,
    parameter int A_PRESET = 1,
    parameter int B_PRESET = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_a,
    input  logic tick_b,
    input  logic clr_a,
    input  logic clr_b,
    input  logic nine_a,
    input  logic nine_b,
    output logic [$clog2(A_MOD)+$clog2(B_MOD)-1:0] q_out
);
    localparam int AW = $clog2(A_MOD);
    localparam int BW = $clog2(B_MOD);
    localparam int QW = AW + BW;
    localparam logic [QW-1:0] NINE_VAL = {BW'(B_PRESET), AW'(A_PRESET)};

    logic          fall_a, fall_b;
    logic          clr_all, preset_all;
    stage_act_e    act_a, act_b;
    logic [AW-1:0] cnt_a;
    logic [BW-1:0] cnt_b;

    ddc_fall_detect u_edge_a (.clk(clk), .rst_n(rst_n), .lvl_in(tick_a), .fall(fall_a));
    ddc_fall_detect u_edge_b (.clk(clk), .rst_n(rst_n), .lvl_in(tick_b), .fall(fall_b));

    // Gate the clear and the preset from their two inputs each.
    always_comb begin
        clr_all    = clr_a & clr_b;
        preset_all = nine_a & nine_b;
    end

    // Per-stage action by priority: preset, then clear, then count edge.
    always_comb begin
        if (preset_all)   act_a = ACT_PRESET;
        else if (clr_all) act_a = ACT_CLEAR;
        else if (fall_a)  act_a = ACT_STEP;
        else              act_a = ACT_HOLD;
        if (preset_all)   act_b = ACT_PRESET;
        else if (clr_all) act_b = ACT_CLEAR;
        else if (fall_b)  act_b = ACT_STEP;
        else              act_b = ACT_HOLD;
    end

    ddc_stage #(.MOD(A_MOD), .PRESET(A_PRESET)) u_stage_a (
        .clk(clk), .rst_n(rst_n), .act(act_a), .cnt(cnt_a));
    ddc_stage #(.MOD(B_MOD), .PRESET(B_PRESET)) u_stage_b (
        .clk(clk), .rst_n(rst_n), .act(act_b), .cnt(cnt_b));

    // Output word: high stage above low stage.
    always_comb q_out = {cnt_b, cnt_a};

    // R6: the preset loads nine whatever the clear and count inputs do.
    a_r6_preset_nine: assert property (@(posedge clk) disable iff (!rst_n)
        (nine_a && nine_b) |=> q_out == NINE_VAL);
    // R5: the clear without the preset gives zero.
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_a && clr_b && !(nine_a && nine_b)) |=> q_out == '0);
    // R4: no edge and no gated control leaves the output unchanged.
    a_r4_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_a && !fall_b && !(clr_a && clr_b) && !(nine_a && nine_b)) |=> $stable(q_out));
endmodule

// File: tb/dual_decade_counter_test.sv
module dual_decade_counter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_a = 1'b0, tick_b_drv = 1'b0;
    logic clr_a_drv = 1'b0, clr_b_drv = 1'b0;
    logic nine_a = 1'b0, nine_b = 1'b0;
    logic cascade = 1'b0, mod6 = 1'b0;
    logic tick_b, clr_a, clr_b;
    logic [3:0] q_out;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    // Optional external wiring: BCD cascade and modulo-6 clear.
    assign tick_b = cascade ? q_out[0] : tick_b_drv;
    assign clr_a  = mod6 ? (q_out[2] & q_out[1]) : clr_a_drv;
    assign clr_b  = mod6 ? (q_out[2] & q_out[1]) : clr_b_drv;

    dual_decade_counter uut (
        .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
        .clr_a(clr_a), .clr_b(clr_b), .nine_a(nine_a), .nine_b(nine_b),
        .q_out(q_out));

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_a();
        @(negedge clk) tick_a = 1'b1;
        @(negedge clk) tick_a = 1'b0;
        settle(3);
    endtask

    task automatic pulse_b();
        @(negedge clk) tick_b_drv = 1'b1;
        @(negedge clk) tick_b_drv = 1'b0;
        settle(3);
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        settle(2);
        rst_n = 1'b1;
        settle(1);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset state", q_out, 4'b0000);
        pulse_a();
        pulse_b();
        check("R1 nonzero before reset", q_out, 4'b0011);
        do_reset();
        check("R1 reset clears count", q_out, 4'b0000);
    endtask

    task automatic t_div2();
        do_reset();
        for (int k = 1; k <= 4; k++) begin
            pulse_a();
            check("R2 low stage toggles", q_out, 4'((k % 2)));
        end
    endtask

    task automatic t_div5();
        do_reset();
        for (int k = 1; k <= 6; k++) begin
            pulse_b();
            check("R3 high stage step", q_out, 4'((k % 5) * 2));
        end
        pulse_a();
        pulse_b();
        check("R3 low bit kept by high stage", q_out, 4'b0101);
    endtask

    task automatic t_ignore();
        do_reset();
        pulse_a();
        pulse_b();
        @(negedge clk) tick_a = 1'b1;
        tick_b_drv = 1'b1;
        settle(4);
        check("R4 rising edges ignored", q_out, 4'b0011);
        @(negedge clk) clr_a_drv = 1'b1;
        settle(3);
        check("R4 single clear input ignored", q_out, 4'b0011);
        @(negedge clk) clr_a_drv = 1'b0;
        nine_b = 1'b1;
        settle(3);
        check("R4 single preset input ignored", q_out, 4'b0011);
        @(negedge clk) nine_b = 1'b0;
        tick_a = 1'b0;
        tick_b_drv = 1'b0;
        settle(3);
    endtask

    task automatic t_clear();
        do_reset();
        pulse_a();
        pulse_b();
        pulse_b();
        check("R5 setup value", q_out, 4'b0101);
        @(negedge clk) clr_a_drv = 1'b1;
        clr_b_drv = 1'b1;
        settle(1);
        check("R5 clear next edge", q_out, 4'b0000);
        pulse_a();
        pulse_b();
        check("R5 clear overrides count edges", q_out, 4'b0000);
        @(negedge clk) clr_a_drv = 1'b0;
        clr_b_drv = 1'b0;
        pulse_a();
        check("R5 counting resumes after clear", q_out, 4'b0001);
    endtask

    task automatic t_preset();
        do_reset();
        @(negedge clk) clr_a_drv = 1'b1;
        clr_b_drv = 1'b1;
        nine_a = 1'b1;
        nine_b = 1'b1;
        settle(1);
        check("R6 preset wins over clear", q_out, 4'b1001);
        pulse_a();
        pulse_b();
        check("R6 preset holds over count edges", q_out, 4'b1001);
        @(negedge clk) nine_a = 1'b0;
        settle(1);
        check("R5 clear after preset released", q_out, 4'b0000);
        @(negedge clk) clr_a_drv = 1'b0;
        clr_b_drv = 1'b0;
        nine_a = 1'b1;
        settle(1);
        @(negedge clk) nine_a = 1'b0;
        nine_b = 1'b0;
        settle(2);
        check("R6 nine kept after release", q_out, 4'b1001);
    endtask

    task automatic t_bcd();
        do_reset();
        cascade = 1'b1;
        settle(2);
        for (int k = 1; k <= 12; k++) begin
            pulse_a();
            check("R7 BCD count", q_out, 4'(k % 10));
        end
        @(negedge clk) nine_a = 1'b1;
        nine_b = 1'b1;
        @(negedge clk) nine_a = 1'b0;
        nine_b = 1'b0;
        settle(2);
        check("R7 bit 3 high at nine", {3'b000, q_out[3]}, 4'b0001);
        pulse_a();
        check("R7 bit 3 falls on wrap to zero", q_out, 4'b0000);
        cascade = 1'b0;
        settle(2);
    endtask

    task automatic t_mod6();
        do_reset();
        cascade = 1'b1;
        mod6 = 1'b1;
        settle(2);
        for (int k = 1; k <= 13; k++) begin
            pulse_a();
            check("R8 modulo-6 count", q_out, 4'(k % 6));
        end
        mod6 = 1'b0;
        cascade = 1'b0;
        settle(2);
    endtask

    initial begin
        settle(3);
        t_reset();
        t_div2();
        t_div5();
        t_ignore();
        t_clear();
        t_preset();
        t_bcd();
        t_mod6();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule